// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned N-bit operands one bit per clock. Operand A is placed in an accumulator shift register one bit wider than the operands. Operand B is placed in a rotating shift register. Once started, both registers present their least significant bit to a one-bit full adder. The full adder keeps its carry in a flip-flop between cycles. Each sum bit enters the accumulator at its top operand position while the accumulator shifts right. After N shift cycles the low N bits hold the sum. One further cycle writes the final carry into the accumulator's extra top bit, so the full N+1-bit result appears in parallel.

Operand B rotates rather than shifting out, so it survives the addition. A later start with no new load adds B again to the low N bits of the previous result, which makes the block a simple running accumulator. A single-cycle done pulse marks completion. A busy flag covers the whole operation. While busy is high, start requests and operand loads are refused.

Top module: `serial_acc_adder`

## Requirements
- R1: While reset is asserted, and until the first accepted request after reset, busy_o and done_o are low and sum_o is all zeros.
- R2: A load request (load_i high while busy_o is low) makes sum_o equal {1'b0, opa_i} after the next clock edge and stores opb_i as operand B.
- R3: A start request (start_i high while busy_o is low) raises busy_o after the next edge. busy_o stays high for exactly N+1 cycles. In the cycle after the last busy cycle, done_o is high for one cycle with busy_o low.
- R4: When done_o is high, sum_o[N:0] equals the unsigned sum of the accumulator's low N bits and operand B, with sum_o[N] as the carry out. While busy_o is high, sum_o[N] reads 0.
- R5: start_i is ignored while busy_o is high. The operation neither restarts nor lengthens, and its result is unchanged.
- R6: load_i is ignored while busy_o is high. Neither the current result nor operand B for the next addition changes.
- R7: A start with no new load adds the held operand B again to sum_o[N-1:0] of the previous result. The previous top bit is discarded.
- R8: When load_i and start_i are both high in the same idle cycle, the addition uses the operands loaded in that cycle.
- R9: The carry flip-flop is cleared at every accepted start, so a carry out of one addition never enters the next.
- R10: While idle, sum_o holds its value in any cycle without a load or start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load both operands (accepted only when idle) |
| opa_i | input | WIDTH | Operand A, placed into the accumulator |
| opb_i | input | WIDTH | Operand B, placed into the rotating register |
| start_i | input | 1 | Begin an addition (accepted only when idle) |
| busy_o | output | 1 | Addition in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | WIDTH+1 | Accumulator contents, valid result when done_o is high |

## Verification
A wrong carry state shows up in the result as soon as done rises, N+1 cycles after start. Pairs that ripple a carry across every bit, such as all-ones plus one, expose a carry that is dropped or stuck. A shift count that is off by one moves the done pulse by a cycle and leaves the sum misaligned by one bit position, and the busy-length count catches this. A carry that leaks between additions, or an operand B that is not restored after its rotation, only shows up on the following start without a load. Back-to-back accumulations are therefore checked as well as isolated additions.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FINAL = 2'd2
  } sadd_state_e;
endpackage

// File: rtl/sadd_rst_sync.sv
module sadd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic start_ok_o,
  output logic idle_o,
  output logic shift_en_o,
  output logic fin_en_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  sadd_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FINAL;
      end
      ST_FINAL: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign start_ok_o = idle_o && start_i;
  assign shift_en_o = (state_q == ST_SHIFT);
  assign fin_en_o   = (state_q == ST_FINAL);
  assign busy_o     = !idle_o;
  assign done_o     = done_q;
endmodule

// File: rtl/sadd_bit_fa.sv
module sadd_bit_fa (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_o
);
  logic carry_q, carry_d, cout;

  always_comb begin
    sum_o = a_i ^ b_i ^ carry_q;
    cout  = (a_i & b_i) | (a_i & carry_q) | (b_i & carry_q);
    if (clr_i)     carry_d = 1'b0;
    else if (en_i) carry_d = cout;
    else           carry_d = carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/sadd_acc.sv
module sadd_acc #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic             clr_top_i,
  input  logic             shift_i,
  input  logic             sum_bit_i,
  input  logic             fin_i,
  input  logic             carry_i,
  output logic             lsb_o,
  output logic [WIDTH:0]   acc_o
);
  logic [WIDTH:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load_i)    acc_d = {1'b0, opa_i};
    if (clr_top_i) acc_d[WIDTH] = 1'b0;
    if (shift_i)   acc_d[WIDTH-1:0] = {sum_bit_i, acc_q[WIDTH-1:1]};
    if (fin_i)     acc_d[WIDTH] = carry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign lsb_o = acc_q[0];
  assign acc_o = acc_q;
endmodule

// File: rtl/sadd_opb_rot.sv
module sadd_opb_rot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             rot_i,
  output logic             lsb_o
);
  logic [WIDTH-1:0] opb_q, opb_d;

  generate
    if (WIDTH == 1) begin : g_one
      always_comb begin
        opb_d = opb_q;
        if (load_i) opb_d = opb_i;
      end
    end else begin : g_many
      always_comb begin
        opb_d = opb_q;
        if (load_i)     opb_d = opb_i;
        else if (rot_i) opb_d = {opb_q[0], opb_q[WIDTH-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opb_q <= '0;
    else        opb_q <= opb_d;
  end

  assign lsb_o = opb_q[0];
endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH:0]   sum_o
);
  logic rst_n_s;
  logic start_ok, idle, shift_en, fin_en;
  logic load_ok;
  logic a_bit, b_bit, s_bit, carry;

  sadd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  sadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .start_ok_o (start_ok),
    .idle_o     (idle),
    .shift_en_o (shift_en),
    .fin_en_o   (fin_en),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign load_ok = idle && load_i;

  sadd_acc #(.WIDTH(WIDTH)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (load_ok),
    .opa_i     (opa_i),
    .clr_top_i (start_ok),
    .shift_i   (shift_en),
    .sum_bit_i (s_bit),
    .fin_i     (fin_en),
    .carry_i   (carry),
    .lsb_o     (a_bit),
    .acc_o     (sum_o)
  );

  sadd_opb_rot #(.WIDTH(WIDTH)) u_opb (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load_ok),
    .opb_i  (opb_i),
    .rot_i  (shift_en),
    .lsb_o  (b_bit)
  );

  sadd_bit_fa u_fa (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_i   (start_ok),
    .en_i    (shift_en),
    .a_i     (a_bit),
    .b_i     (b_bit),
    .sum_o   (s_bit),
    .carry_o (carry)
  );
endmodule

// File: rtl/sadd_chk.sv
module sadd_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [WIDTH-1:0] opa_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH:0]   sum_o
);
  int   bcnt_q;
  logic busy_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q      <= 0;
      busy_prev_q <= 1'b0;
    end else begin
      busy_prev_q <= busy_o;
      if (busy_o) bcnt_q <= busy_prev_q ? bcnt_q + 1 : 1;
    end
  end

  p_done_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && busy_prev_q));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bcnt_q == WIDTH + 1));

  p_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sum_o[WIDTH]);

  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && load_i) |=> (sum_o == {1'b0, $past(opa_i)}));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i && !start_i) |=> $stable(sum_o));
endmodule

bind serial_acc_adder sadd_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .opa_i   (opa_i),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sum_o   (sum_o)
);

// File: tb/tb_serial_acc_adder.sv
`timescale 1ns/1ps
module tb_serial_acc_adder;
  localparam int W = 8;

  localparam logic [2*W-1:0] VEC [12] = '{
    16'h0000, 16'h0101, 16'hFF01, 16'hFFFF, 16'h8080, 16'h55AA,
    16'h0FF1, 16'h7F01, 16'h1234, 16'hC33C, 16'hA55A, 16'h01FE
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i, start_i;
  logic [W-1:0] opa_i, opb_i;
  logic         busy_o, done_o;
  logic [W:0]   sum_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  serial_acc_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .opa_i(opa_i),
    .opb_i(opb_i), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .sum_o(sum_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load_i = 1'b1; opa_i = a; opb_i = b;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // start at the current negedge; optional stray start/load while busy
  task automatic run(input bit with_load, input logic [W-1:0] a,
                     input logic [W-1:0] b, input bit stray_start,
                     input bit stray_load, output int nbusy);
    int n;
    if (with_load) begin
      load_i = 1'b1; opa_i = a; opb_i = b;
    end
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; load_i = 1'b0;
    n = 0;
    while (!done_o && n < 100) begin
      if (busy_o) n++;
      if (n == 3) begin
        if (stray_start) start_i = 1'b1;
        if (stray_load) begin
          load_i = 1'b1; opa_i = ~a; opb_i = 8'h3C;
        end
      end else begin
        start_i = 1'b0; load_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0; load_i = 1'b0;
    nbusy = n;
  endtask

  initial begin
    int nb;
    logic [W:0] exp;
    rst_n = 1'b0; load_i = 1'b0; start_i = 1'b0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0 && sum_o == '0, "R1 reset", int'(sum_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0 && sum_o == '0, "R1 after release", int'(sum_o), 0);

    // table walk
    foreach (VEC[i]) begin
      logic [W-1:0] a, b;
      a = VEC[i][2*W-1:W];
      b = VEC[i][W-1:0];
      exp = {1'b0, a} + {1'b0, b};
      load_ops(a, b);
      check(sum_o == {1'b0, a}, "R2 load", int'(sum_o), int'({1'b0, a}));
      run(1'b0, a, b, 1'b0, 1'b0, nb);
      check(nb == W + 1, "R3 busy length", nb, W + 1);
      check(done_o && !busy_o, "R3 done pulse", int'(done_o), 1);
      check(sum_o == exp, "R4 sum", int'(sum_o), int'(exp));
      @(negedge clk);
      check(!done_o, "R3 done single", int'(done_o), 0);
    end

    // R10 idle hold
    exp = sum_o;
    repeat (5) @(negedge clk);
    check(sum_o == exp, "R10 hold", int'(sum_o), int'(exp));

    // R5 stray start while busy
    load_ops(8'h3A, 8'h47);
    run(1'b0, 8'h3A, 8'h47, 1'b1, 1'b0, nb);
    check(nb == W + 1, "R5 length unchanged", nb, W + 1);
    check(sum_o == 9'h081, "R5 result", int'(sum_o), 'h081);
    @(negedge clk);
    check(!busy_o, "R5 no restart", int'(busy_o), 0);

    // R6 stray load while busy, then R7 reuse of B
    load_ops(8'hC8, 8'h64);
    run(1'b0, 8'hC8, 8'h64, 1'b0, 1'b1, nb);
    check(sum_o == 9'h12C, "R6 result unaffected", int'(sum_o), 'h12C);
    @(negedge clk);
    run(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, nb);
    check(sum_o == 9'h090, "R6 R7 B kept, top dropped", int'(sum_o), 'h090);

    // R9 carry cleared: FF+01 then re-add 01 to low bits 00
    @(negedge clk);
    run(1'b1, 8'hFF, 8'h01, 1'b0, 1'b0, nb);
    check(sum_o == 9'h100, "R9 all ones plus one", int'(sum_o), 'h100);
    @(negedge clk);
    run(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, nb);
    check(sum_o == 9'h001, "R9 no carry leak", int'(sum_o), 'h001);

    // R8 load and start together
    load_ops(8'h11, 8'h22);
    run(1'b1, 8'hF0, 8'h0F, 1'b0, 1'b0, nb);
    check(sum_o == 9'h0FF, "R8 same-cycle load", int'(sum_o), 'h0FF);
    @(negedge clk);
    run(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, nb);
    check(sum_o == 9'h10E, "R7 accumulate", int'(sum_o), 'h10E);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule